// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a 12-bit serial converter that powers itself down after every conversion. When a start request is accepted, the controller raises the chip-select line to open a frame. It holds the serial clock high for a wake-up interval so that the converter can power up. It then produces sixteen serial clock periods, each derived from the system clock through a programmable half-period divider. The input line is sampled on every rising edge of the serial clock. The first four bits received must be zero. The remaining twelve bits, most significant first, form the result.

When the sixteenth rising edge is reached, chip-select drops. The 12-bit result appears together with a framing-error flag, and a valid strobe marks it for one system clock. A rest timer then keeps the controller from accepting a new request until the converter has stayed powered down for the programmed minimum. A ready output tells the requester when a start will be taken.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After a synchronous reset, cs_o is 0, sclk_o is 1, valid_o is 0 and ready_o is 1.
- R2: A start_i seen high at a clock edge while ready_o is high raises cs_o after that edge. sclk_o then stays high for WAKE_CYC plus HALF_DIV system cycles before its first falling edge.
- R3: Within a frame, sclk_o makes exactly 16 periods. Each period starts low for HALF_DIV system cycles and then goes high for HALF_DIV cycles. Outside a frame sclk_o is 1.
- R4: sdata_i is sampled at the system clock edge where sclk_o goes high. Sample k (k = 1..16) is bit k of the serial word. Samples 5..16 become data_o[11] down to data_o[0].
- R5: frame_err_o is 1 when any of samples 1..4 is 1, and 0 when all four are 0. It is updated together with data_o.
- R6: At the edge of the 16th rising sclk_o edge, cs_o returns to 0. valid_o is then 1 for exactly one system cycle.
- R7: ready_o is 0 from the accepting edge until REST_CYC cycles after the frame ends. A start_i that arrives while ready_o is 0 has no effect on cs_o or sclk_o. A start_i held high starts frames at exactly this minimum spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to read one sample |
| sdata_i | input | 1 | Serial data from the converter |
| cs_o | output | 1 | Chip-select; high during a frame |
| sclk_o | output | 1 | Serial clock, idles high |
| ready_o | output | 1 | A start will be accepted at the next edge |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| data_o | output | 12 | Last conversion result |
| frame_err_o | output | 1 | Leading bits of the last frame were not all zero |

## Verification
The hardest case to reach from the ports is a start request that falls exactly on the boundary of the rest interval. If the request arrives one cycle early, it must be dropped. If it arrives in the first ready cycle, it must open a frame. The stimulus reaches this boundary by holding start_i high across several frames, so that every cycle of the rest window sees a request. Further single start pulses are fired in the middle of a frame and in the middle of the rest window. A reset is also applied while the serial clock is low.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAKE  = 2'd1,
        ST_SHIFT = 2'd2
    } rd_state_e;

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
    parameter int HALF_DIV = 7
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o
);
    localparam int CW = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } div_t;

    div_t d, q;
    logic rise;

    always_comb begin
        d    = q;
        rise = 1'b0;
        if (!run_i) begin
            d.cnt  = '0;
            d.sclk = 1'b1;
        end else if (q.cnt == LAST) begin
            d.cnt  = '0;
            d.sclk = ~q.sclk;
            rise   = ~q.sclk;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q.cnt  <= '0;
            q.sclk <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk_o = q.sclk;
    assign rise_o = rise;
endmodule

// File: rtl/adc_shift_cap.sv
module adc_shift_cap #(
    parameter int LEAD_BITS = 4,
    parameter int DATA_BITS = 12
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 clear_i,
    input  logic                 take_i,
    input  logic                 din_i,
    output logic                 last_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 err_o,
    output logic                 valid_o
);
    localparam int FW = LEAD_BITS + DATA_BITS;
    localparam int BW = $clog2(FW);
    localparam logic [BW-1:0] LAST = BW'(FW - 1);

    typedef struct packed {
        logic [FW-2:0]        sh;
        logic [BW-1:0]        cnt;
        logic [DATA_BITS-1:0] data;
        logic                 err;
        logic                 valid;
    } cap_t;

    cap_t d, q;
    logic last;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        last    = take_i && (q.cnt == LAST);
        if (clear_i) begin
            d.cnt = '0;
        end else if (take_i) begin
            d.sh  = {q.sh[FW-3:0], din_i};
            d.cnt = q.cnt + 1'b1;
            if (last) begin
                d.data  = {q.sh[DATA_BITS-2:0], din_i};
                d.err   = |q.sh[FW-2 -: LEAD_BITS];
                d.valid = 1'b1;
                d.cnt   = '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign last_o  = last;
    assign data_o  = q.data;
    assign err_o   = q.err;
    assign valid_o = q.valid;
endmodule

// File: rtl/adc_rest_timer.sv
module adc_rest_timer #(
    parameter int REST_CYC = 925
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic load_i,
    output logic busy_o
);
    localparam int TW = $clog2(REST_CYC + 1);
    localparam logic [TW-1:0] INIT = TW'(REST_CYC - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          busy;
    } rest_t;

    rest_t d, q;

    always_comb begin
        d = q;
        if (load_i) begin
            d.cnt  = INIT;
            d.busy = 1'b1;
        end else if (q.busy) begin
            if (q.cnt == '0) begin
                d.busy = 1'b0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o = q.busy;
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
    parameter int HALF_DIV  = 7,
    parameter int WAKE_CYC  = 125,
    parameter int REST_CYC  = 925,
    parameter int LEAD_BITS = 4,
    parameter int DATA_BITS = 12
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 start_i,
    input  logic                 sdata_i,
    output logic                 cs_o,
    output logic                 sclk_o,
    output logic                 ready_o,
    output logic                 valid_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 frame_err_o
);
    import adc_rd_pkg::*;

    localparam int WW = $clog2(WAKE_CYC + 1);
    localparam logic [WW-1:0] WLAST = WW'(WAKE_CYC - 1);

    typedef struct packed {
        rd_state_e     st;
        logic [WW-1:0] wcnt;
        logic          cs;
    } top_t;

    top_t d, q;
    logic run, rise, last, busy, ready, load;

    adc_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (run),
        .sclk_o (sclk_o),
        .rise_o (rise)
    );

    adc_shift_cap #(.LEAD_BITS(LEAD_BITS), .DATA_BITS(DATA_BITS)) u_cap (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (~run),
        .take_i  (rise),
        .din_i   (sdata_i),
        .last_o  (last),
        .data_o  (data_o),
        .err_o   (frame_err_o),
        .valid_o (valid_o)
    );

    adc_rest_timer #(.REST_CYC(REST_CYC)) u_rest (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load),
        .busy_o (busy)
    );

    always_comb begin
        d     = q;
        run   = (q.st == ST_SHIFT);
        ready = (q.st == ST_IDLE) && !busy;
        load  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i && ready) begin
                    d.st   = ST_WAKE;
                    d.wcnt = '0;
                    d.cs   = 1'b1;
                end
            end
            ST_WAKE: begin
                if (q.wcnt == WLAST) begin
                    d.st = ST_SHIFT;
                end else begin
                    d.wcnt = q.wcnt + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (last) begin
                    d.st = ST_IDLE;
                    d.cs = 1'b0;
                    load = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q.st   <= ST_IDLE;
            q.wcnt <= '0;
            q.cs   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cs_o    = q.cs;
    assign ready_o = ready;
endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker (
    input logic clk_i,
    input logic rst_i,
    input logic start_i,
    input logic cs_o,
    input logic sclk_o,
    input logic ready_o,
    input logic valid_o
);
    // R7: a frame opens only on an accepted request
    p_cs_rise_needs_ready_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(cs_o) |-> $past(ready_o && start_i));

    // R7: never ready while a frame is open
    p_ready_idle_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |-> !cs_o);

    // R6: result strobe lasts one cycle
    p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o);

    // R6: strobe coincides with the close of the frame
    p_valid_cs_fall_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> (!cs_o && $past(cs_o)));

    // R3: serial clock is low only inside a frame
    p_sclk_low_in_frame_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !sclk_o |-> cs_o);
endmodule

bind adc_rd_ctrl adc_rd_checker u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start_i),
    .cs_o    (cs_o),
    .sclk_o  (sclk_o),
    .ready_o (ready_o),
    .valid_o (valid_o)
);

// File: tb/sim_adc_rd_ctrl.sv
`timescale 1ns/1ps
module sim_adc_rd_ctrl;
    localparam int HALF = 7;
    localparam int WAKE = 125;
    localparam int REST = 925;
    localparam int FEND = WAKE + 32 * HALF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic sdata = 1'b0;
    logic cs, sclk, ready, valid, ferr;
    logic [11:0] data;

    always #4 clk = ~clk;

    adc_rd_ctrl u0 (
        .clk_i(clk), .rst_i(rst), .start_i(start), .sdata_i(sdata),
        .cs_o(cs), .sclk_o(sclk), .ready_o(ready), .valid_o(valid),
        .data_o(data), .frame_err_o(ferr)
    );

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // word list fed by the converter model, one per accepted frame
    logic [15:0] words [0:9];
    int          widx = 0;
    logic [15:0] cur_word = 16'h0;
    int          bidx = 0;

    initial begin
        words[0] = 16'h0ABC; words[1] = 16'h0FFF; words[2] = 16'h0000;
        words[3] = 16'h0555; words[4] = 16'h8123; words[5] = 16'h1AAA;
        words[6] = 16'h0800; words[7] = 16'h0001; words[8] = 16'h4F00;
        words[9] = 16'h0C3C;
    end

    // converter model: next bit after every falling serial clock edge
    always @(posedge cs) begin bidx = 0; sdata = 1'b0; end
    always @(negedge sclk) begin
        if (cs && bidx < 16) begin
            sdata = cur_word[15 - bidx];
            bidx++;
        end
    end

    // behavioural reference
    bit          m_act = 0;
    int          m_t = 0;
    int          m_gap = 0;
    bit          m_valid = 0;
    logic [11:0] m_data = 0;
    bit          m_err = 0;

    function automatic int exp_sclk(input bit act, input int t);
        int h;
        if (!act || t < WAKE) return 1;
        h = (t - WAKE) / HALF;
        return (h % 2 == 0) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        live <= 1'b1;
        if (rst) begin
            m_act = 0; m_t = 0; m_gap = 0; m_valid = 0; m_data = 0; m_err = 0;
        end else begin
            m_valid = 0;
            if (m_act) begin
                m_t++;
                if (m_t == FEND) begin
                    m_act = 0;
                    m_valid = 1;
                    m_gap = REST;
                    m_data = cur_word[11:0];
                    m_err = |cur_word[15:12];
                end
            end else if (m_gap > 0) begin
                m_gap--;
            end else if (start) begin
                m_act = 1;
                m_t = 0;
                cur_word = (widx < 10) ? words[widx] : 16'h0F0F;
                widx++;
            end
        end
    end

    // compare on every clock
    always @(negedge clk) begin
        if (live && !done) begin
            chk("R2", "cs_o", int'(cs), int'(m_act));
            chk("R3", "sclk_o", int'(sclk), exp_sclk(m_act, m_t));
            chk("R7", "ready_o", int'(ready), int'(!m_act && m_gap == 0));
            chk("R6", "valid_o", int'(valid), int'(m_valid));
            if (m_valid) begin
                chk("R4", "data_o", int'(data), int'(m_data));
                chk("R5", "frame_err_o", int'(ferr), int'(m_err));
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_ready();
        do @(negedge clk); while (!ready);
    endtask

    task automatic wait_valid();
        do @(negedge clk); while (!valid);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1", "reset cs_o", int'(cs), 0);
        chk("R1", "reset sclk_o", int'(sclk), 1);
        chk("R1", "reset valid_o", int'(valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ready after reset", int'(ready), 1);

        // single frame with a stray request mid-frame (R7 ignore)
        pulse_start();
        repeat (200) @(negedge clk);
        pulse_start();
        wait_valid();
        // stray request inside the rest window
        repeat (300) @(negedge clk);
        pulse_start();
        wait_ready();
        pulse_start();
        wait_valid();

        // R7 held request: frames at minimum spacing
        wait_ready();
        start = 1'b1;
        repeat (4) wait_valid();
        @(negedge clk); start = 1'b0;

        // remaining words with idle gaps
        for (int i = 0; i < 3; i++) begin
            wait_ready();
            repeat (17 * (i + 1)) @(negedge clk);
            pulse_start();
            wait_valid();
        end

        // reset while the serial clock is low (R1)
        wait_ready();
        pulse_start();
        do @(negedge clk); while (sclk);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "mid-frame reset cs_o", int'(cs), 0);
        chk("R1", "mid-frame reset sclk_o", int'(sclk), 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ready after mid-frame reset", int'(ready), 1);
        pulse_start();
        wait_valid();
        repeat (20) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule